// File: doc/BRIEF.md
# Primary interrupt status aggregator

This block is the upper stage of a two-level interrupt controller. Up to six secondary interrupt banks each raise a request toward each of two independent bus masters. For every master the block combines those requests into a fixed-position status byte. Bit n of that byte stands for bank n. Each master gets its own active-low interrupt line, which is low while its status byte is non-zero.

The block does no masking. Masking is done entirely inside the secondary banks, so a status bit is a live OR of that bank's request toward that master and is never latched. A master reads its own status byte through a simple registered read port. For test, software can write a force register that ORs chosen bits into the status of both masters.

Top module: `prim_irq_agg`

## Requirements
- R1: Bit n (n = 0..5) of master k's status byte equals bank n's request toward master k, ORed with forced bit n. Bits 6 and 7 always read zero.
- R2: Master 0's status is read at address 0x01 and master 1's at address 0x02. The force register reads back at address 0x03. Any other address reads 0x00. Read data appears on `rd_data` one clock after the address is presented.
- R3: In the clock after master k's status byte is non-zero, `irq_n[k]` is 0. It is 1 after a cycle in which that status byte is zero.
- R4: Masking is not possible at this stage. A request toward one master sets only that master's status bit, and the other master's status and line stay unaffected.
- R5: A write (`wr_en`=1) to address 0x03 loads `wr_data[5:0]` into the force register, which takes effect from the next clock. Bits 7:6 of the written data are dropped. Writes to any other address leave the force register unchanged.
- R6: Writing 0x00 to address 0x03 clears all forced bits. Reset clears the force register, sets both `irq_n` lines to 1 and sets `rd_data` to 0x00.
- R7: A status bit is not held. Once the bank drops its request and the bit is not forced, the bit reads 0 and the line returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_req | input | 12 | Bank requests; bits [k*6 +: 6] go to master k |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, registered |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_n | output | 2 | Active-low interrupt line per master |

## Verification
The assertions check four things on every cycle. Each line follows its master's status one cycle later. The pad bits of read data stay zero, and unmapped addresses read zero. The force register changes only on a write to its address and clears on a zero write. With no requests and no forced bits, both lines are high. The bench scenarios cover the rest: the exact bit positions per master, the separation between the two masters, how forced bits merge with live requests, the dropping of high written bits, and the live clearing of status once a request falls.

// File: rtl/prim_irq_pkg.sv
package prim_irq_pkg;
    // status of master k sits at STAT_BASE + k; force register follows them
    localparam int STAT_BASE = 1;

    function automatic int force_addr(input int num_masters);
        return STAT_BASE + num_masters;
    endfunction
endpackage

// File: rtl/prim_irq_merge.sv
module prim_irq_merge #(
    parameter int NUM_BANKS = 6,
    parameter int STAT_W    = 8
) (
    input  logic [NUM_BANKS-1:0] req,
    input  logic [STAT_W-1:0]    force_bits,
    output logic [STAT_W-1:0]    status
);
    always_comb begin
        status = STAT_W'(req) | force_bits;
    end
endmodule

// File: rtl/prim_irq_rdmux.sv
module prim_irq_rdmux
    import prim_irq_pkg::*;
#(
    parameter int NUM_MASTERS = 2,
    parameter int STAT_W      = 8,
    parameter int ADDR_W      = 8
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_MASTERS*STAT_W-1:0] status_all,
    input  logic [STAT_W-1:0]             force_bits,
    output logic [STAT_W-1:0]             rdata
);
    localparam int FORCE_ADDR = force_addr(NUM_MASTERS);

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_MASTERS; k++) begin
            if (addr == ADDR_W'(STAT_BASE + k)) begin
                rdata = status_all[k*STAT_W +: STAT_W];
            end
        end
        if (addr == ADDR_W'(FORCE_ADDR)) begin
            rdata = force_bits;
        end
    end
endmodule

// File: rtl/prim_irq_agg.sv
module prim_irq_agg
    import prim_irq_pkg::*;
#(
    parameter int NUM_BANKS   = 6,
    parameter int NUM_MASTERS = 2,
    parameter int STAT_W      = 8,
    parameter int ADDR_W      = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_MASTERS*NUM_BANKS-1:0] bank_req,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [STAT_W-1:0]                rd_data,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [STAT_W-1:0]                wr_data,
    output logic [NUM_MASTERS-1:0]           irq_n
);
    localparam int FORCE_ADDR = force_addr(NUM_MASTERS);
    localparam logic [STAT_W-1:0] POP_MASK = STAT_W'((1 << NUM_BANKS) - 1);

    typedef struct packed {
        logic [NUM_MASTERS-1:0] irq_n;
        logic [STAT_W-1:0]      rd_data;
        logic [STAT_W-1:0]      force_bits;
    } state_t;

    state_t state_d, state_q;
    logic [NUM_MASTERS*STAT_W-1:0] status_all;
    logic [STAT_W-1:0]             rdata_mux;
    logic                          force_wr;

    for (genvar k = 0; k < NUM_MASTERS; k++) begin : g_master
        prim_irq_merge #(
            .NUM_BANKS (NUM_BANKS),
            .STAT_W    (STAT_W)
        ) i_merge (
            .req        (bank_req[k*NUM_BANKS +: NUM_BANKS]),
            .force_bits (state_q.force_bits),
            .status     (status_all[k*STAT_W +: STAT_W])
        );

        // R3: line follows its master's status one cycle later
        assert_line_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (status_all[k*STAT_W +: STAT_W] != '0) |=> (irq_n[k] == 1'b0));
        assert_line_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (status_all[k*STAT_W +: STAT_W] == '0) |=> (irq_n[k] == 1'b1));
    end

    prim_irq_rdmux #(
        .NUM_MASTERS (NUM_MASTERS),
        .STAT_W      (STAT_W),
        .ADDR_W      (ADDR_W)
    ) i_rdmux (
        .addr       (rd_addr),
        .status_all (status_all),
        .force_bits (state_q.force_bits),
        .rdata      (rdata_mux)
    );

    assign force_wr = wr_en && (wr_addr == ADDR_W'(FORCE_ADDR));

    always_comb begin
        state_d = state_q;
        if (force_wr) begin
            state_d.force_bits = wr_data & POP_MASK;
        end
        for (int k = 0; k < NUM_MASTERS; k++) begin
            state_d.irq_n[k] = (status_all[k*STAT_W +: STAT_W] == '0);
        end
        state_d.rd_data = rdata_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.irq_n      <= '1;
            state_q.rd_data    <= '0;
            state_q.force_bits <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = state_q.rd_data;
    assign irq_n   = state_q.irq_n;

    // R1: unpopulated status positions never read as set
    assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~POP_MASK) == '0);

    // R2: addresses outside the map read zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr < ADDR_W'(STAT_BASE)) || (rd_addr > ADDR_W'(FORCE_ADDR)))
        |=> (rd_data == '0));

    // R5: force register only changes on a write to its address
    assert_force_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !force_wr |=> $stable(state_q.force_bits));

    // R6: a zero write empties the force register
    assert_force_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_wr && (wr_data == '0)) |=> (state_q.force_bits == '0));

    // R7: with nothing requested and nothing forced, both lines go high
    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_req == '0) && (state_q.force_bits == '0)) |=> (irq_n == '1));
endmodule

// File: tb/test_prim_irq_agg.sv
module test_prim_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bank_req = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prim_irq_agg i_prim_irq_agg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_req (bank_req),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .irq_n    (irq_n)
    );

    // request pattern: [5:0] toward master 0, [11:6] toward master 1
    localparam logic [11:0] VEC_REQ [8] = '{
        12'h000, 12'h001, 12'h020, 12'h040,
        12'h800, 12'hFFF, 12'h2A5, 12'h03F
    };
    localparam logic [1:0] VEC_IRQN [8] = '{
        2'b11, 2'b10, 2'b10, 2'b01,
        2'b01, 2'b00, 2'b00, 2'b10
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] addr, output logic [7:0] val);
        @(negedge clk);
        rd_addr = addr;
        @(negedge clk);
        val = rd_data;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = addr;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_req(input logic [11:0] r);
        @(negedge clk);
        bank_req = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6 reset irq_n", {6'b0, irq_n}, 8'h03);
        chk("R6 reset rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        rd(8'h03, v); chk("R6 reset force reg", v, 8'h00);
        rd(8'h01, v); chk("R2 idle status m0", v, 8'h00);

        // table walk: R1 R3 R4
        for (int i = 0; i < 8; i++) begin
            set_req(VEC_REQ[i]);
            chk("R3 irq_n table", {6'b0, irq_n}, {6'b0, VEC_IRQN[i]});
            rd(8'h01, v); chk("R1 status m0 table", v, {2'b00, VEC_REQ[i][5:0]});
            rd(8'h02, v); chk("R4 status m1 table", v, {2'b00, VEC_REQ[i][11:6]});
        end

        // R7: live status clears when request falls
        set_req(12'h400);
        rd(8'h02, v); chk("R7 status m1 set", v, 8'h10);
        set_req(12'h000);
        rd(8'h02, v); chk("R7 status m1 cleared", v, 8'h00);
        chk("R7 irq_n idle", {6'b0, irq_n}, 8'h03);

        // R2: unmapped addresses
        set_req(12'hFFF);
        rd(8'h00, v); chk("R2 addr 0x00", v, 8'h00);
        rd(8'h04, v); chk("R2 addr 0x04", v, 8'h00);
        rd(8'hFF, v); chk("R2 addr 0xFF", v, 8'h00);
        set_req(12'h000);

        // R5: forcing hits both masters, high bits dropped
        wr(8'h03, 8'h05);
        @(negedge clk);
        chk("R5 irq_n forced", {6'b0, irq_n}, 8'h00);
        rd(8'h01, v); chk("R5 forced m0", v, 8'h05);
        rd(8'h02, v); chk("R5 forced m1", v, 8'h05);
        set_req(12'h002);
        rd(8'h01, v); chk("R1 forced or req m0", v, 8'h07);
        set_req(12'h000);
        wr(8'h03, 8'hFF);
        rd(8'h03, v); chk("R5 high bits dropped", v, 8'h3F);
        rd(8'h01, v); chk("R1 pad bits zero", v, 8'h3F);

        // R6: zero write clears
        wr(8'h03, 8'h00);
        @(negedge clk);
        rd(8'h03, v); chk("R6 cleared force", v, 8'h00);
        chk("R6 irq_n after clear", {6'b0, irq_n}, 8'h03);

        // R5: write elsewhere ignored
        wr(8'h01, 8'h3F);
        wr(8'h02, 8'h3F);
        @(negedge clk);
        rd(8'h03, v); chk("R5 other write ignored", v, 8'h00);
        chk("R5 irq_n after other write", {6'b0, irq_n}, 8'h03);

        // R6: reset clears forced bits mid-run
        wr(8'h03, 8'h21);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R6 reset irq_n mid-run", {6'b0, irq_n}, 8'h03);
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h03, v); chk("R6 reset force mid-run", v, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule